// File: doc/BRIEF.md
# Column Command Read/Write Turnaround Spacer

This block sits on the controller side of a packet-based memory column interface. A request source offers column reads and writes one at a time through a valid/ready handshake. The block accepts a request only when every spacing rule for that request's type has been met. An accepted request appears on the column command output in the same cycle. The rules are:
- a minimum interval between any two column commands;
- a write-to-read turnaround;
- a read-to-write turnaround.

The read-to-write turnaround is not a fixed number. The block derives it from the read latency, the write latency, the column interval and the idle bubble the data bus needs when its driver changes direction.

The block also schedules the data bus. Every accepted write reserves a write-data slot a write latency later. Every accepted read reserves a read-return slot a read latency later. The bus direction output follows the write slots. A collision flag marks any cycle in which a write slot and a read slot land together. All timing values are static configuration inputs counted in clock cycles. Banks, row activation, refresh and the physical layer are handled elsewhere.

Top module: `col_turnaround_spacer`

## Requirements
- R1: In the first cycle after reset, with no command issued since, `req_ready` is high for both a read and a write request, and `dq_drive_write`, `dq_read_slot` and `dq_collision` are low.
- R2: Two column commands are issued at least `cfg_t_cc` cycles apart, counted from one issue cycle to the next, whatever their types. A command of the same type as the previous one waits for this interval only.
- R3: A read is not issued until at least `cfg_t_wr2rd` cycles after the most recent write issue. No bank or address takes part in this rule.
- R4: A write is not issued until at least G cycles after the most recent read issue. G = `cfg_t_rd_lat` − `cfg_t_wr_lat` + `cfg_t_cc` + `cfg_t_bubble`, taken as a signed sum. A result below 1 is treated as 1.
- R5: `req_ready` is high exactly when every rule from R2 to R4 that applies to the type on `req_write` (1 = write, 0 = read) is met. `col_valid` equals `req_valid` AND `req_ready` in the same cycle. `col_write` equals `req_write` while `col_valid` is high and is low otherwise.
- R6: A write issued in cycle t drives `dq_drive_write` high in cycle t + `cfg_t_wr_lat`. The latency must be between 1 and MAX_LAT.
- R7: A read issued in cycle t drives `dq_read_slot` high in cycle t + `cfg_t_rd_lat`. The latency must be between 1 and MAX_LAT.
- R8: `dq_drive_write` is high only in cycles holding a scheduled write-data slot. In a cycle holding only a read-return slot it is low.
- R9: `dq_collision` is high in exactly those cycles where a write-data slot and a read-return slot coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_t_cc | input | TW | Minimum column command interval, cycles |
| cfg_t_wr2rd | input | TW | Write-to-read turnaround, cycles |
| cfg_t_rd_lat | input | TW | Read command to read data, cycles |
| cfg_t_wr_lat | input | TW | Write command to write data, cycles |
| cfg_t_bubble | input | TW | Idle bus cycles needed between read data and write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request type: 1 write, 0 read |
| req_ready | output | 1 | Request may be taken this cycle |
| col_valid | output | 1 | Column command slot used this cycle |
| col_write | output | 1 | Issued command is a write |
| dq_drive_write | output | 1 | Data bus carries write data this cycle |
| dq_read_slot | output | 1 | Data bus carries read data this cycle |
| dq_collision | output | 1 | Write and read data slots overlap this cycle |

## Verification
The bench builds the block with TW = 6 and MAX_LAT = 16. Most scenarios run with an interval of 2, a write-to-read gap of 5, a read latency of 6, a write latency of 3 and a bubble of 1, which gives a derived read-to-write gap of 6. These values leave a clear window between the interval rule and each turnaround rule, so a stalled request shows which counter held it back. A second configuration uses a short read latency and a long write latency. It drives the derived gap below 1, which exercises the clamp, and it makes a write slot and a read slot coincide, so the collision flag can be provoked.

// File: rtl/col_sp_pkg.sv
package col_sp_pkg;

    typedef enum logic {
        COL_RD = 1'b0,
        COL_WR = 1'b1
    } col_op_e;

    typedef enum int {
        RULE_ANY = 0,
        RULE_W2R = 1,
        RULE_R2W = 2
    } col_rule_e;

    localparam int NUM_RULES = 3;

    typedef struct packed {
        logic    vld;
        col_op_e op;
    } col_cmd_t;

    // Read-to-write gap: data-bus latency difference plus interval plus bubble, at least 1
    function automatic int rw_gap(input int rd_lat, input int wr_lat,
                                  input int t_cc, input int bubble);
        int g;
        g = rd_lat - wr_lat + t_cc + bubble;
        if (g < 1) g = 1;
        return g;
    endfunction

    // Counter reload so that the rule is met exactly span cycles after the load
    function automatic int reload_of(input int span);
        return (span < 1) ? 0 : span - 1;
    endfunction

endpackage

// File: rtl/col_gap_timer.sv
module col_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] reload,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= reload;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> expired); // R1

endmodule

// File: rtl/col_slot_line.sv
module col_slot_line #(
    parameter int DEPTH = 16,
    parameter int LW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mark,
    input  logic [LW-1:0] lat,
    output logic          slot_now
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] line_q, line_d;
    logic [IW-1:0]    tap;

    always_comb begin
        if (int'(lat) < 1)          tap = '0;
        else if (int'(lat) > DEPTH) tap = IW'(DEPTH - 1);
        else                        tap = IW'(int'(lat) - 1);
    end

    always_comb begin
        line_d = line_q >> 1;
        for (int i = 0; i < DEPTH; i++) begin
            if (mark && (int'(tap) == i)) line_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign slot_now = line_q[0];

    AST_SLOT_EMPTY_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !slot_now); // R1

endmodule

// File: rtl/col_turnaround_spacer.sv
module col_turnaround_spacer
    import col_sp_pkg::*;
#(
    parameter int TW      = 6,
    parameter int MAX_LAT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] cfg_t_cc,
    input  logic [TW-1:0] cfg_t_wr2rd,
    input  logic [TW-1:0] cfg_t_rd_lat,
    input  logic [TW-1:0] cfg_t_wr_lat,
    input  logic [TW-1:0] cfg_t_bubble,
    input  logic          req_valid,
    input  logic          req_write,
    output logic          req_ready,
    output logic          col_valid,
    output logic          col_write,
    output logic          dq_drive_write,
    output logic          dq_read_slot,
    output logic          dq_collision
);
    localparam int CW  = TW + 2;
    localparam int SAT = (1 << CW) - 1;

    col_cmd_t       cmd;
    logic           issue, ready_rd, ready_wr;
    logic [CW-1:0]  span   [NUM_RULES];
    logic           loads  [NUM_RULES];
    logic           clear  [NUM_RULES];

    // Spans for each spacing rule
    always_comb begin
        span[RULE_ANY] = CW'(reload_of(int'(cfg_t_cc)));
        span[RULE_W2R] = CW'(reload_of(int'(cfg_t_wr2rd)));
        span[RULE_R2W] = CW'(reload_of(rw_gap(int'(cfg_t_rd_lat), int'(cfg_t_wr_lat),
                                              int'(cfg_t_cc), int'(cfg_t_bubble))));
    end

    assign cmd.vld = issue;
    assign cmd.op  = col_op_e'(req_write);

    always_comb begin
        loads[RULE_ANY] = cmd.vld;
        loads[RULE_W2R] = cmd.vld && (cmd.op == COL_WR);
        loads[RULE_R2W] = cmd.vld && (cmd.op == COL_RD);
    end

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
        col_gap_timer #(.CW(CW)) u_timer (
            .clk    (clk),
            .rst    (rst),
            .load   (loads[r]),
            .reload (span[r]),
            .expired(clear[r])
        );
    end

    assign ready_rd  = clear[RULE_ANY] && clear[RULE_W2R];
    assign ready_wr  = clear[RULE_ANY] && clear[RULE_R2W];
    assign req_ready = req_write ? ready_wr : ready_rd;
    assign issue     = req_valid && req_ready;
    assign col_valid = cmd.vld;
    assign col_write = cmd.vld && (cmd.op == COL_WR);

    logic wr_slot, rd_slot;

    col_slot_line #(.DEPTH(MAX_LAT), .LW(TW)) u_wr_line (
        .clk     (clk),
        .rst     (rst),
        .mark    (col_write),
        .lat     (cfg_t_wr_lat),
        .slot_now(wr_slot)
    );

    col_slot_line #(.DEPTH(MAX_LAT), .LW(TW)) u_rd_line (
        .clk     (clk),
        .rst     (rst),
        .mark    (cmd.vld && (cmd.op == COL_RD)),
        .lat     (cfg_t_rd_lat),
        .slot_now(rd_slot)
    );

    assign dq_drive_write = wr_slot;
    assign dq_read_slot   = rd_slot;
    assign dq_collision   = wr_slot && rd_slot;

    // Independent elapsed-cycle counters used only by the spacing assertions
    logic [CW-1:0] since_any, since_wr, since_rd;
    int            gap_chk;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= CW'(SAT);
            since_wr  <= CW'(SAT);
            since_rd  <= CW'(SAT);
        end else begin
            since_any <= issue ? CW'(1) : (since_any == CW'(SAT) ? since_any : since_any + 1'b1);
            since_wr  <= (issue && req_write) ? CW'(1)
                         : (since_wr == CW'(SAT) ? since_wr : since_wr + 1'b1);
            since_rd  <= (issue && !req_write) ? CW'(1)
                         : (since_rd == CW'(SAT) ? since_rd : since_rd + 1'b1);
        end
    end

    assign gap_chk = int'(cfg_t_rd_lat) - int'(cfg_t_wr_lat) + int'(cfg_t_cc) + int'(cfg_t_bubble);

    AST_CC_SPACING: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (int'(since_any) >= int'(cfg_t_cc))); // R2

    AST_WR_TO_RD: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_write) |-> (int'(since_wr) >= int'(cfg_t_wr2rd))); // R3

    AST_RD_TO_WR: assert property (@(posedge clk) disable iff (rst)
        col_write |-> (int'(since_rd) >= gap_chk)); // R4

    AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (req_valid && (col_write == req_write))); // R5

    AST_FRESH_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (ready_rd && ready_wr)); // R1

endmodule

// File: tb/tb_col_turnaround_spacer.sv
module tb_col_turnaround_spacer;

    localparam int TW      = 6;
    localparam int MAX_LAT = 16;
    localparam int HIST    = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] cfg_t_cc, cfg_t_wr2rd, cfg_t_rd_lat, cfg_t_wr_lat, cfg_t_bubble;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready, col_valid, col_write;
    logic          dq_drive_write, dq_read_slot, dq_collision;

    always #2 clk = ~clk; // 250 MHz

    col_turnaround_spacer #(.TW(TW), .MAX_LAT(MAX_LAT)) dut (
        .clk(clk), .rst(rst),
        .cfg_t_cc(cfg_t_cc), .cfg_t_wr2rd(cfg_t_wr2rd),
        .cfg_t_rd_lat(cfg_t_rd_lat), .cfg_t_wr_lat(cfg_t_wr_lat),
        .cfg_t_bubble(cfg_t_bubble),
        .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
        .col_valid(col_valid), .col_write(col_write),
        .dq_drive_write(dq_drive_write), .dq_read_slot(dq_read_slot),
        .dq_collision(dq_collision)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc;
    int last_any, last_wr, last_rd;
    bit exp_w [HIST];
    bit exp_r [HIST];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic int gap_rw();
        int g;
        g = int'(cfg_t_rd_lat) - int'(cfg_t_wr_lat) + int'(cfg_t_cc) + int'(cfg_t_bubble);
        return (g < 1) ? 1 : g;
    endfunction

    task automatic apply_cfg(input int cc, input int w2r, input int rl, input int wl, input int bub);
        cfg_t_cc = TW'(cc); cfg_t_wr2rd = TW'(w2r);
        cfg_t_rd_lat = TW'(rl); cfg_t_wr_lat = TW'(wl); cfg_t_bubble = TW'(bub);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        cyc = 0;
        last_any = -1000; last_wr = -1000; last_rd = -1000;
        for (int i = 0; i < HIST; i++) begin exp_w[i] = 1'b0; exp_r[i] = 1'b0; end
    endtask

    // One cycle: drive, check all outputs against the model, advance
    task automatic step(input bit v, input bit w, output bit took);
        bit ok;
        req_valid = v; req_write = w;
        #1;
        ok = ((cyc - last_any) >= int'(cfg_t_cc)) &&
             (w ? ((cyc - last_rd) >= gap_rw()) : ((cyc - last_wr) >= int'(cfg_t_wr2rd)));
        check(w ? "R4" : "R3", "req_ready vs turnaround", int'(req_ready), int'(ok));
        check("R5", "col_valid", int'(col_valid), int'(v && ok));
        check("R5", "col_write", int'(col_write), int'(v && ok && w));
        check("R6", "write data slot", int'(dq_drive_write), int'(exp_w[cyc]));
        check("R7", "read data slot", int'(dq_read_slot), int'(exp_r[cyc]));
        if (exp_r[cyc] && !exp_w[cyc])
            check("R8", "direction low on read slot", int'(dq_drive_write), 0);
        check("R9", "collision", int'(dq_collision), int'(exp_w[cyc] && exp_r[cyc]));
        took = v && ok;
        if (took) begin
            last_any = cyc;
            if (w) begin last_wr = cyc; exp_w[cyc + int'(cfg_t_wr_lat)] = 1'b1; end
            else   begin last_rd = cyc; exp_r[cyc + int'(cfg_t_rd_lat)] = 1'b1; end
        end
        @(posedge clk);
        #1 cyc++;
    endtask

    task automatic idle(input int n);
        bit t;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, t);
    endtask

    // Hold a request until it is taken; return its issue cycle
    task automatic push(input bit w, output int at);
        bit t;
        t = 1'b0;
        at = -1;
        for (int k = 0; k < 64 && !t; k++) begin
            at = cyc;
            step(1'b1, w, t);
        end
    endtask

    task automatic t_reset();
        apply_cfg(2, 5, 6, 3, 1);
        do_reset();
        req_valid = 1'b0; req_write = 1'b1; #1;
        check("R1", "ready for write after reset", int'(req_ready), 1);
        req_write = 1'b0; #1;
        check("R1", "ready for read after reset", int'(req_ready), 1);
        check("R1", "no write slot after reset", int'(dq_drive_write), 0);
        check("R1", "no read slot after reset", int'(dq_read_slot), 0);
        check("R1", "no collision after reset", int'(dq_collision), 0);
        idle(1);
    endtask

    task automatic t_same_type();
        int a, b, c;
        apply_cfg(2, 5, 6, 3, 1);
        do_reset();
        push(1'b1, a); push(1'b1, b); push(1'b1, c);
        check("R2", "write-write spacing", b - a, 2);
        check("R2", "write-write spacing 2", c - b, 2);
        idle(8);
        push(1'b0, a); push(1'b0, b);
        check("R2", "read-read spacing", b - a, 2);
        idle(10);
    endtask

    task automatic t_wr_then_rd();
        int a, b;
        apply_cfg(2, 5, 6, 3, 1);
        do_reset();
        push(1'b1, a); push(1'b0, b);
        check("R3", "write-to-read gap", b - a, 5);
        idle(10);
    endtask

    task automatic t_rd_then_wr();
        int a, b;
        apply_cfg(2, 5, 6, 3, 1);
        do_reset();
        push(1'b0, a); push(1'b1, b);
        check("R4", "read-to-write gap", b - a, 6);
        idle(6);
        check("R8", "write slot seen after last write", int'(exp_w[b + 3]), 1);
        idle(4);
    endtask

    task automatic t_mixed();
        int a;
        apply_cfg(3, 7, 5, 2, 2);
        do_reset();
        push(1'b1, a); push(1'b1, a); push(1'b0, a); push(1'b0, a);
        push(1'b1, a); push(1'b0, a); push(1'b1, a);
        idle(12);
    endtask

    task automatic t_collision();
        int a, b;
        apply_cfg(1, 2, 2, 4, 0); // derived read-to-write gap clamps to 1
        do_reset();
        push(1'b1, a); push(1'b0, b);
        check("R3", "short write-to-read gap", b - a, 2);
        idle(1);
        check("R9", "collision flagged", int'(dq_collision), 1);
        idle(3);
        push(1'b0, a); push(1'b1, b);
        check("R4", "clamped read-to-write gap", b - a, 1);
        idle(8);
    endtask

    initial begin
        t_reset();
        t_same_type();
        t_wr_then_rd();
        t_rd_then_wr();
        t_mixed();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule